// File: doc/BRIEF.md
# Link Energy-Detect Power Controller

This block sets the power state of a multi-port network device. A host loads a 2-bit operating mode and an 8-bit go-sleep interval through two write strobes. From these values the controller drives enable lines for the PLL clock, the per-port PHYs, the MAC, the host interface, the receiver's auxiliary blocks and the receive energy-detect circuit. Cable energy comes in as a synchronous level.

In energy-detect mode the controller has two substates, awake and asleep. It counts prescaled ticks while no energy is present and clears that count whenever energy appears. Once the count passes the go-sleep value it drops everything except the energy detector. While asleep it sends a short heartbeat pulse at a fixed interval. The next clock edge that sees energy wakes it. An active-low hardware power-down input turns every enable off and holds the whole controller in reset, so releasing it brings back the power-up state. A per-port power-down bit turns off a single PHY whatever the mode.

Top module: `lnk_pwr_ctrl`

## Requirements
- R1: Mode code 00 (normal) asserts pll_en, mac_en, host_en, rx_aux_en and every phy_en bit whose port_pd bit is 0. It deasserts edet_en, and link_pulse stays 0.
- R2: After rst, mode_o reads 00 and the go-sleep interval holds GO_SLEEP_RST.
- R3: Mode code 01 (energy detect) starts in the awake substate. It asserts the same enables as R1 and also asserts edet_en.
- R4: In mode 01, let energy_in be continuously 0 from a given clock edge. The controller enters the asleep substate (TICK_DIV*(G+1)) edges after that edge, where G is the go-sleep interval. A single edge with energy_in = 1 restarts the count.
- R5: In the asleep substate, edet_en is 1 and pll_en, mac_en, host_en, rx_aux_en and all phy_en bits are 0.
- R6: In the asleep substate, the first edge that samples energy_in = 1 returns the controller to awake. The R3 enables apply and link_pulse reads 0 right after that edge.
- R7: While asleep, link_pulse rises TICK_DIV*PULSE_TICKS edges after entry into sleep and stays high for PULSE_W cycles. It repeats every TICK_DIV*PULSE_TICKS cycles.
- R8: Suppose a mode write with a code other than 01 is sampled at an edge. Right after that edge the enables of the new mode apply, even from the asleep substate.
- R9: Mode code 10 (soft power-down) asserts only host_en. Mode code 11 (power saving) asserts pll_en, mac_en, host_en and the unmasked phy_en bits, with rx_aux_en and edet_en at 0.
- R10: While pwr_dn_n is 0, every enable and link_pulse is 0 and mode and go-sleep writes are ignored. After release, mode_o is 00 and the go-sleep interval is GO_SLEEP_RST.
- R11: With port_pd[i] = 1, phy_en[i] is 0 in every mode. The other ports are not affected.
- R12: A go-sleep write sampled at an edge sets the interval G used by R4 for every later idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Hardware power-down, active low |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode code to write |
| sleep_wr | input | 1 | Go-sleep interval write strobe |
| sleep_wdata | input | 8 | Go-sleep interval in ticks |
| port_pd | input | NPORT | Per-port PHY power-down bits |
| energy_in | input | 1 | Cable energy present |
| mode_o | output | 2 | Current mode code |
| pll_en | output | 1 | PLL clock enable |
| phy_en | output | NPORT | Per-port PHY enable |
| mac_en | output | 1 | MAC enable |
| host_en | output | 1 | Host interface enable |
| rx_aux_en | output | 1 | Receiver auxiliary block enable |
| edet_en | output | 1 | Receive energy-detect enable |
| link_pulse | output | 1 | Heartbeat pulse while asleep |

## Verification
Enables follow the mode and substate registers through combinational decode, so a mode write or a wake shows up right after the edge that samples it. Hardware power-down and port masks show up at once. Sleep entry comes TICK_DIV*(G+1) edges after energy is lost, and the heartbeat rises TICK_DIV*PULSE_TICKS edges after that. The bench drives inputs on falling edges and counts rising edges from that point. It checks one edge before each due time, where the old value must still hold, and again on the due edge.

// File: rtl/lnk_pwr_pkg.sv
package lnk_pwr_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_EDET   = 2'b01,
        PM_SOFTPD = 2'b10,
        PM_PSAVE  = 2'b11
    } pm_mode_e;

    typedef enum logic {
        ED_AWAKE  = 1'b0,
        ED_ASLEEP = 1'b1
    } ed_state_e;

    typedef struct packed {
        logic pll;
        logic phy;
        logic mac;
        logic host;
        logic rx_aux;
        logic edet;
    } pm_en_s;

    localparam pm_en_s EN_NONE = '{pll: 1'b0, phy: 1'b0, mac: 1'b0, host: 1'b0, rx_aux: 1'b0, edet: 1'b0};

    function automatic pm_en_s pm_decode(pm_mode_e m, ed_state_e s);
        pm_en_s e;
        e = EN_NONE;
        case (m)
            PM_NORMAL: begin
                e.pll = 1'b1; e.phy = 1'b1; e.mac = 1'b1; e.host = 1'b1; e.rx_aux = 1'b1;
            end
            PM_EDET: begin
                e.edet = 1'b1;
                if (s == ED_AWAKE) begin
                    e.pll = 1'b1; e.phy = 1'b1; e.mac = 1'b1; e.host = 1'b1; e.rx_aux = 1'b1;
                end
            end
            PM_SOFTPD: begin
                e.host = 1'b1;
            end
            PM_PSAVE: begin
                e.pll = 1'b1; e.phy = 1'b1; e.mac = 1'b1; e.host = 1'b1;
            end
            default: e = EN_NONE;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lnk_pwr_regs.sv
module lnk_pwr_regs
    import lnk_pwr_pkg::*;
#(
    parameter int unsigned SLEEP_W = 8,
    parameter logic [SLEEP_W-1:0] SLEEP_RST = '0
) (
    input  logic               clk,
    input  logic               rst_i,
    input  logic               mode_wr,
    input  logic [1:0]         mode_wdata,
    input  logic               sleep_wr,
    input  logic [SLEEP_W-1:0] sleep_wdata,
    output pm_mode_e           mode_q,
    output logic [SLEEP_W-1:0] sleep_q
);

    always_ff @(posedge clk) begin
        if (rst_i) begin
            mode_q  <= PM_NORMAL;
            sleep_q <= SLEEP_RST;
        end else begin
            if (mode_wr)  mode_q  <= pm_mode_e'(mode_wdata);
            if (sleep_wr) sleep_q <= sleep_wdata;
        end
    end

    // R8
    mode_write_chk: assert property (@(posedge clk) disable iff (rst_i)
        mode_wr |=> (mode_q == pm_mode_e'($past(mode_wdata))));

    // R12
    sleep_write_chk: assert property (@(posedge clk) disable iff (rst_i)
        sleep_wr |=> (sleep_q == $past(sleep_wdata)));

endmodule

// File: rtl/lnk_pwr_tick.sv
module lnk_pwr_tick #(
    parameter int unsigned DIV = 200000
) (
    input  logic clk,
    input  logic rst_i,
    input  logic run,
    output logic tick
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst_i || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R4
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst_i)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/lnk_pwr_edfsm.sv
module lnk_pwr_edfsm
    import lnk_pwr_pkg::*;
#(
    parameter int unsigned SLEEP_W = 8
) (
    input  logic               clk,
    input  logic               rst_i,
    input  pm_mode_e           mode_q,
    input  logic               energy,
    input  logic               tick,
    input  logic [SLEEP_W-1:0] sleep_q,
    output ed_state_e          state_q
);

    logic [SLEEP_W-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst_i || mode_q != PM_EDET) begin
            state_q <= ED_AWAKE;
            idle_q  <= '0;
        end else begin
            case (state_q)
                ED_AWAKE: begin
                    if (energy) begin
                        idle_q <= '0;
                    end else if (tick) begin
                        if (idle_q >= sleep_q) begin
                            state_q <= ED_ASLEEP;
                            idle_q  <= '0;
                        end else begin
                            idle_q <= idle_q + 1'b1;
                        end
                    end
                end
                ED_ASLEEP: begin
                    idle_q <= '0;
                    if (energy) state_q <= ED_AWAKE;
                end
                default: state_q <= ED_AWAKE;
            endcase
        end
    end

    // R6
    wake_chk: assert property (@(posedge clk) disable iff (rst_i)
        (state_q == ED_ASLEEP && energy && mode_q == PM_EDET) |=> (state_q == ED_AWAKE));

    // R4
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst_i)
        $rose(state_q == ED_ASLEEP) |-> $past(!energy && tick));

    // R8
    mode_exit_chk: assert property (@(posedge clk) disable iff (rst_i)
        (mode_q != PM_EDET) |=> (state_q == ED_AWAKE));

endmodule

// File: rtl/lnk_pwr_beacon.sv
module lnk_pwr_beacon #(
    parameter int unsigned PULSE_TICKS = 1000,
    parameter int unsigned PULSE_W     = 24
) (
    input  logic clk,
    input  logic rst_i,
    input  logic asleep,
    input  logic tick,
    output logic pulse
);

    localparam int unsigned PCW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam int unsigned WCW = $clog2(PULSE_W + 1);
    localparam logic [PCW-1:0] P_LAST = PCW'(PULSE_TICKS - 1);
    localparam logic [WCW-1:0] W_LOAD = WCW'(PULSE_W);

    logic [PCW-1:0] pcnt;
    logic [WCW-1:0] wcnt;
    logic           fire;

    assign fire = tick && (pcnt == P_LAST);

    always_ff @(posedge clk) begin
        if (rst_i || !asleep) begin
            pcnt <= '0;
            wcnt <= '0;
        end else begin
            if (tick) pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
            if (fire) begin
                wcnt <= W_LOAD;
            end else if (wcnt != '0) begin
                wcnt <= wcnt - 1'b1;
            end
        end
    end

    assign pulse = asleep && (wcnt != '0);

    // R7
    pulse_on_tick_chk: assert property (@(posedge clk) disable iff (rst_i)
        $rose(wcnt != '0) |-> $past(tick));

endmodule

// File: rtl/lnk_pwr_ctrl.sv
module lnk_pwr_ctrl
    import lnk_pwr_pkg::*;
#(
    parameter int unsigned NPORT        = 5,
    parameter int unsigned TICK_DIV     = 200000,
    parameter int unsigned SLEEP_W      = 8,
    parameter int unsigned GO_SLEEP_RST = 100,
    parameter int unsigned PULSE_TICKS  = 1000,
    parameter int unsigned PULSE_W      = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_dn_n,
    input  logic               mode_wr,
    input  logic [1:0]         mode_wdata,
    input  logic               sleep_wr,
    input  logic [SLEEP_W-1:0] sleep_wdata,
    input  logic [NPORT-1:0]   port_pd,
    input  logic               energy_in,
    output logic [1:0]         mode_o,
    output logic               pll_en,
    output logic [NPORT-1:0]   phy_en,
    output logic               mac_en,
    output logic               host_en,
    output logic               rx_aux_en,
    output logic               edet_en,
    output logic               link_pulse
);

    logic               rst_i;
    pm_mode_e           mode_q;
    logic [SLEEP_W-1:0] sleep_q;
    ed_state_e          state_q;
    logic               tick;
    logic               beacon;
    pm_en_s             en;

    assign rst_i = rst || !pwr_dn_n;

    lnk_pwr_regs #(
        .SLEEP_W   (SLEEP_W),
        .SLEEP_RST (SLEEP_W'(GO_SLEEP_RST))
    ) u_regs (
        .clk         (clk),
        .rst_i       (rst_i),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .sleep_wr    (sleep_wr),
        .sleep_wdata (sleep_wdata),
        .mode_q      (mode_q),
        .sleep_q     (sleep_q)
    );

    lnk_pwr_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_i (rst_i),
        .run   (mode_q == PM_EDET && !energy_in),
        .tick  (tick)
    );

    lnk_pwr_edfsm #(
        .SLEEP_W (SLEEP_W)
    ) u_fsm (
        .clk     (clk),
        .rst_i   (rst_i),
        .mode_q  (mode_q),
        .energy  (energy_in),
        .tick    (tick),
        .sleep_q (sleep_q),
        .state_q (state_q)
    );

    lnk_pwr_beacon #(
        .PULSE_TICKS (PULSE_TICKS),
        .PULSE_W     (PULSE_W)
    ) u_beacon (
        .clk    (clk),
        .rst_i  (rst_i),
        .asleep (mode_q == PM_EDET && state_q == ED_ASLEEP),
        .tick   (tick),
        .pulse  (beacon)
    );

    always_comb begin
        en = EN_NONE;
        if (pwr_dn_n) en = pm_decode(mode_q, state_q);
    end

    assign mode_o     = mode_q;
    assign pll_en     = en.pll;
    assign mac_en     = en.mac;
    assign host_en    = en.host;
    assign rx_aux_en  = en.rx_aux;
    assign edet_en    = en.edet;
    assign link_pulse = beacon && pwr_dn_n;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_port
            assign phy_en[i] = en.phy && !port_pd[i];

            // R11
            port_mask_chk: assert property (@(posedge clk) disable iff (rst)
                port_pd[i] |-> !phy_en[i]);
        end
    endgenerate

    // R10
    hw_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |-> !(pll_en || mac_en || host_en || rx_aux_en || edet_en || link_pulse) && (phy_en == '0));

    // R10
    release_state_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_dn_n) |-> (mode_o == 2'b00));

    // R5
    sleep_enables_chk: assert property (@(posedge clk) disable iff (rst_i)
        link_pulse |-> (edet_en && !pll_en && !mac_en && !host_en && (phy_en == '0)));

endmodule

// File: tb/lnk_pwr_ctrl_bench.sv
module lnk_pwr_ctrl_bench;

    localparam int NPORT = 5;
    localparam int DIV   = 4;
    localparam int GRST  = 10;
    localparam int PT    = 3;
    localparam int PW    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwr_dn_n = 1'b1;
    logic             mode_wr = 1'b0;
    logic [1:0]       mode_wdata = 2'b00;
    logic             sleep_wr = 1'b0;
    logic [7:0]       sleep_wdata = 8'd0;
    logic [NPORT-1:0] port_pd = '0;
    logic             energy_in = 1'b1;
    logic [1:0]       mode_o;
    logic             pll_en, mac_en, host_en, rx_aux_en, edet_en, link_pulse;
    logic [NPORT-1:0] phy_en;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lnk_pwr_ctrl #(
        .NPORT (NPORT), .TICK_DIV (DIV), .SLEEP_W (8),
        .GO_SLEEP_RST (GRST), .PULSE_TICKS (PT), .PULSE_W (PW)
    ) u_lnk_pwr_ctrl (
        .clk (clk), .rst (rst), .pwr_dn_n (pwr_dn_n),
        .mode_wr (mode_wr), .mode_wdata (mode_wdata),
        .sleep_wr (sleep_wr), .sleep_wdata (sleep_wdata),
        .port_pd (port_pd), .energy_in (energy_in),
        .mode_o (mode_o), .pll_en (pll_en), .phy_en (phy_en),
        .mac_en (mac_en), .host_en (host_en), .rx_aux_en (rx_aux_en),
        .edet_en (edet_en), .link_pulse (link_pulse)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // enables packed as {pll, mac, host, rx_aux, edet}
    task automatic check_en(input string req, input logic [4:0] exp5, input logic [NPORT-1:0] exp_phy);
        check(req, "enables", int'({pll_en, mac_en, host_en, rx_aux_en, edet_en}), int'(exp5));
        check(req, "phy_en", int'(phy_en), int'(exp_phy));
    endtask

    task automatic wr_mode(input logic [1:0] m);
        mode_wr = 1'b1; mode_wdata = m;
        step(1);
        mode_wr = 1'b0;
    endtask

    task automatic wr_sleep(input logic [7:0] g);
        sleep_wr = 1'b1; sleep_wdata = g;
        step(1);
        sleep_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R2", "mode_o", int'(mode_o), 0);
        check_en("R1", 5'b11110, 5'b11111);
        check("R1", "link_pulse", int'(link_pulse), 0);
    endtask

    task automatic t_port_pd;
        port_pd = 5'b00100;
        step(1);
        check_en("R11", 5'b11110, 5'b11011);
        port_pd = 5'b10001;
        step(1);
        check_en("R11", 5'b11110, 5'b01110);
        port_pd = '0;
    endtask

    task automatic t_modes;
        wr_mode(2'b10);
        check_en("R9", 5'b00100, 5'b00000);
        wr_mode(2'b11);
        check_en("R9", 5'b11100, 5'b11111);
        wr_mode(2'b00);
        check_en("R1", 5'b11110, 5'b11111);
    endtask

    task automatic t_sleep_default;
        wr_mode(2'b01);
        check_en("R3", 5'b11111, 5'b11111);
        energy_in = 1'b0;
        step((GRST + 1) * DIV - 1);
        check_en("R4", 5'b11111, 5'b11111);
        step(1);
        check_en("R5", 5'b00001, 5'b00000);
        energy_in = 1'b1;
        step(1);
        check_en("R6", 5'b11111, 5'b11111);
    endtask

    task automatic t_idle_clear;
        wr_sleep(8'd2);
        energy_in = 1'b0;
        step(8);
        energy_in = 1'b1;
        step(1);
        energy_in = 1'b0;
        step(3 * DIV - 1);
        check_en("R12", 5'b11111, 5'b11111);
        step(1);
        check_en("R4", 5'b00001, 5'b00000);
    endtask

    task automatic t_beacon;
        step(PT * DIV - 1);
        check("R7", "link_pulse before", int'(link_pulse), 0);
        step(1);
        check("R7", "link_pulse rise", int'(link_pulse), 1);
        step(PW - 1);
        check("R7", "link_pulse held", int'(link_pulse), 1);
        step(1);
        check("R7", "link_pulse fall", int'(link_pulse), 0);
        step(PT * DIV - PW - 1);
        check("R7", "link_pulse gap", int'(link_pulse), 0);
        step(1);
        check("R7", "link_pulse repeat", int'(link_pulse), 1);
        energy_in = 1'b1;
        step(1);
        check("R6", "link_pulse after wake", int'(link_pulse), 0);
        check_en("R6", 5'b11111, 5'b11111);
    endtask

    task automatic t_exit;
        wr_sleep(8'd0);
        energy_in = 1'b0;
        step(DIV);
        check_en("R4", 5'b00001, 5'b00000);
        wr_mode(2'b00);
        check_en("R8", 5'b11110, 5'b11111);
        check("R8", "link_pulse", int'(link_pulse), 0);
        energy_in = 1'b1;
    endtask

    task automatic t_hwpd;
        wr_mode(2'b11);
        wr_sleep(8'd5);
        pwr_dn_n = 1'b0;
        step(1);
        check_en("R10", 5'b00000, 5'b00000);
        wr_mode(2'b10);
        check_en("R10", 5'b00000, 5'b00000);
        pwr_dn_n = 1'b1;
        step(1);
        check("R10", "mode_o after release", int'(mode_o), 0);
        check_en("R10", 5'b11110, 5'b11111);
        wr_mode(2'b01);
        energy_in = 1'b0;
        step((GRST + 1) * DIV - 1);
        check_en("R10", 5'b11111, 5'b11111);
        step(1);
        check_en("R10", 5'b00001, 5'b00000);
        energy_in = 1'b1;
        step(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_port_pd();
        t_modes();
        t_sleep_default();
        t_idle_clear();
        t_beacon();
        t_exit();
        t_hwpd();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule